// File: doc/BRIEF.md
# Quasi-Reset Configuration Request Responder

This block is a per-port filter on the received TLP header path. When its quasi-reset input is low it has no effect: each header goes straight through to the port's normal logic, and the normal logic's back-pressure is passed back to the sender. When quasi-reset is high, the block consumes every header itself. It answers configuration requests with a completion header that carries no data. A type 0 configuration request gets Configuration Request Retry Status, whatever register it addresses. A type 1 configuration request gets Unsupported Request status.

In quasi-reset mode, every other packet is discarded. The block still frees the receive buffer space of each consumed packet. It does so by pulsing a credit-return strobe that gives the packet's flow-control class and its count of data credits. The block handles headers only; the receive path deals with payloads. The mode is latched for each packet, so a header that is stalled when quasi-reset toggles is still handled in the mode it arrived under.

Top module: `qrst_cfg_responder`

## Requirements
- R1: After reset, `cpl_valid` and `crd_valid` are low.
- R2: With the effective mode normal (quasi-reset low), the following hold, and neither a completion nor a credit strobe is produced:
  - `out_valid` equals `in_valid`.
  - `out_hdr` equals `in_hdr`.
  - `in_ready` equals `out_ready`.
- R3: Headers are 4 DWs, with DW0 in `in_hdr[127:96]`, DW1 in `[95:64]` and DW2 in `[63:32]`. DW0 holds fmt in bits [31:29], type in [28:24] and length in [9:0]. DW1 holds the requester ID in [31:16] and the tag in [15:8]. In quasi-reset mode, a header with type 00100 and fmt bit 2 clear is a type 0 configuration request, either read or write. Such a request, whatever its DW2 register address, yields a completion with status 010 in the cycle after it is accepted.
- R4: In quasi-reset mode, a header with type 00101 and fmt bit 2 clear is a type 1 configuration request, and yields a completion with status 001.
- R5: The completion header is `{DW0, DW1, DW2}` on `cpl_hdr[95:0]`:
  - DW0 is 32'h0A00_0000: fmt 000, type 01010, length 0.
  - DW1 is `{cpl_id, status[2:0], 1'b0, 12'd4}`.
  - DW2 is `{requester ID, tag, 8'h00}`.
- R6: In quasi-reset mode, any other header is accepted with `in_ready` high and discarded. It produces no `out_valid` and no completion.
- R7: Every header consumed in quasi-reset mode, configuration requests included, raises `crd_valid` for exactly one cycle, the cycle after acceptance. That pulse means one header credit. `crd_class` is 0 for posted packets (type 00000 with fmt bit 1 set, or type 10xxx), 2 for completions (type 0101x), and 1 for all others.
- R8: `crd_data` is ceil(length/4) when fmt bit 1 is set, with length 0 standing for 1024. It is 0 when fmt bit 1 is clear.
- R9: While a presented header waits with `in_ready` low, a change of `qrst` does not change how that header is handled. A new `qrst` value applies from the next header.
- R10: While `cpl_valid` is high and `cpl_ready` is low, `cpl_hdr` holds steady. A configuration request is not accepted while the completion slot is full and not draining, so no request is lost and none is answered twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qrst | input | 1 | Quasi-reset mode request |
| cpl_id | input | 16 | Completer ID placed in completions |
| in_valid | input | 1 | Received header valid |
| in_ready | output | 1 | Received header accepted |
| in_hdr | input | 128 | Received 4-DW header |
| out_valid | output | 1 | Pass-through header valid |
| out_ready | input | 1 | Normal port logic can take a header |
| out_hdr | output | 128 | Pass-through header |
| cpl_valid | output | 1 | Completion header valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_hdr | output | 96 | Completion 3-DW header |
| crd_valid | output | 1 | Credit return strobe (one header credit) |
| crd_class | output | 2 | Credit class: 0 posted, 1 non-posted, 2 completion |
| crd_data | output | 9 | Data credits returned (16-byte units) |

## Verification
Two events can fall in the same cycle. One is the completion slot draining a finished answer. The other is the same slot loading the answer to the next configuration request. The bench provokes this by holding `cpl_ready` low so a second request stalls behind the first. It then releases `cpl_ready` in the cycle the second request is waiting. The expected result is one handover on that edge: the first completion was seen steady throughout the stall, the second appears on the next cycle, and exactly one credit pulse follows. A second such overlap is a `qrst` toggle while a pass-through header is stalled. It is judged by the header still leaving on `out_hdr` with no credit pulse.

// File: rtl/qrst_pkg.sv
package qrst_pkg;
  localparam int DW_W    = 32;
  localparam int HDR_DWS = 4;
  localparam int CPL_DWS = 3;
  localparam int HDR_W   = DW_W * HDR_DWS;
  localparam int CPL_W   = DW_W * CPL_DWS;
  localparam int ID_W    = 16;
  localparam int TAG_W   = 8;
  localparam int LEN_W   = 10;
  localparam int CRD_W   = LEN_W - 1;   // 1024 DW / 4 = 256 credits max

  typedef enum logic [1:0] {
    CC_POSTED  = 2'd0,
    CC_NONPOST = 2'd1,
    CC_CPL     = 2'd2
  } crd_class_e;

  localparam logic [2:0] ST_UR  = 3'b001;
  localparam logic [2:0] ST_CRS = 3'b010;
  localparam logic [4:0] TY_CFG0 = 5'b00100;
  localparam logic [4:0] TY_CFG1 = 5'b00101;

  function automatic crd_class_e class_of(input logic [2:0] fmt, input logic [4:0] typ);
    if (typ[4:3] == 2'b10)                 return CC_POSTED;   // messages
    if (typ == 5'b00000 && fmt[1])         return CC_POSTED;   // memory write
    if (typ[4:1] == 4'b0101)               return CC_CPL;      // completions
    return CC_NONPOST;
  endfunction

  function automatic logic [CRD_W-1:0] data_credits(input logic [2:0] fmt,
                                                    input logic [LEN_W-1:0] len);
    logic [LEN_W:0] dws;
    logic [LEN_W:0] rounded;
    dws     = (len == '0) ? (LEN_W+1)'(1 << LEN_W) : {1'b0, len};
    rounded = dws + (LEN_W+1)'(3);
    return fmt[1] ? rounded[LEN_W:2] : '0;
  endfunction

  function automatic logic [CPL_W-1:0] build_cpl(input logic [ID_W-1:0] cid,
                                                 input logic [ID_W-1:0] rid,
                                                 input logic [TAG_W-1:0] tag,
                                                 input logic [2:0] status);
    logic [DW_W-1:0] d0, d1, d2;
    d0 = {3'b000, 5'b01010, 14'd0, 10'd0};
    d1 = {cid, status, 1'b0, 12'd4};
    d2 = {rid, tag, 8'h00};
    return {d0, d1, d2};
  endfunction
endpackage

// File: rtl/qrst_decode.sv
module qrst_decode
  import qrst_pkg::*;
(
  input  logic [2:0]       fmt,
  input  logic [4:0]       typ,
  input  logic [LEN_W-1:0] len,
  output logic             is_cfg0,
  output logic             is_cfg1,
  output crd_class_e       cls,
  output logic [CRD_W-1:0] dcred
);
  always_comb begin
    is_cfg0 = !fmt[2] && (typ == TY_CFG0);
    is_cfg1 = !fmt[2] && (typ == TY_CFG1);
    cls     = class_of(fmt, typ);
    dcred   = data_credits(fmt, len);
  end
endmodule

// File: rtl/qrst_cpl_stage.sv
module qrst_cpl_stage
  import qrst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CPL_W-1:0] hdr_in,
  input  logic             ready,
  output logic             valid,
  output logic [CPL_W-1:0] hdr,
  output logic             space
);
  assign space = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      hdr   <= '0;
    end else if (space) begin
      valid <= load;
      if (load) hdr <= hdr_in;
    end
  end

  // R10: a stalled completion keeps its header
  a_r10_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(hdr)));
  // R10: the top never loads into a full, stalled slot
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> space);
endmodule

// File: rtl/qrst_credit_out.sv
module qrst_credit_out
  import qrst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  crd_class_e       cls_in,
  input  logic [CRD_W-1:0] dcred_in,
  output logic             valid,
  output logic [1:0]       cls,
  output logic [CRD_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cls   <= 2'd0;
      data  <= '0;
    end else begin
      valid <= fire;
      if (fire) begin
        cls  <= cls_in;
        data <= dcred_in;
      end
    end
  end

  // R7: class is one of the three defined codes
  a_r7_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cls != 2'd3));
  // R8: never more than 256 data credits
  a_r8_data_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (data <= CRD_W'(256)));
endmodule

// File: rtl/qrst_cfg_responder.sv
module qrst_cfg_responder
  import qrst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qrst,
  input  logic [ID_W-1:0]  cpl_id,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [HDR_W-1:0] in_hdr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [HDR_W-1:0] out_hdr,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [CPL_W-1:0] cpl_hdr,
  output logic             crd_valid,
  output logic [1:0]       crd_class,
  output logic [CRD_W-1:0] crd_data
);
  localparam int DW0_LO = HDR_W - DW_W;
  localparam int DW1_LO = HDR_W - 2*DW_W;

  logic             pend_q, pend_mode_q, quasi;
  logic             is_cfg0, is_cfg1, is_cfg;
  crd_class_e       cls;
  logic [CRD_W-1:0] dcred;
  logic             cpl_space, fire, eat, cpl_load;
  logic [CPL_W-1:0] cpl_next;
  logic [ID_W-1:0]  rid;
  logic [TAG_W-1:0] tag;

  // mode is frozen while a header sits unaccepted
  assign quasi = pend_q ? pend_mode_q : qrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_mode_q <= 1'b0;
    end else begin
      pend_q      <= in_valid && !in_ready;
      pend_mode_q <= quasi;
    end
  end

  qrst_decode u_dec (
    .fmt     (in_hdr[DW0_LO+29 +: 3]),
    .typ     (in_hdr[DW0_LO+24 +: 5]),
    .len     (in_hdr[DW0_LO +: LEN_W]),
    .is_cfg0 (is_cfg0),
    .is_cfg1 (is_cfg1),
    .cls     (cls),
    .dcred   (dcred)
  );

  assign is_cfg    = is_cfg0 || is_cfg1;
  assign rid       = in_hdr[DW1_LO+16 +: ID_W];
  assign tag       = in_hdr[DW1_LO+8 +: TAG_W];
  assign in_ready  = quasi ? (is_cfg ? cpl_space : 1'b1) : out_ready;
  assign out_valid = in_valid && !quasi;
  assign out_hdr   = in_hdr;
  assign fire      = in_valid && in_ready;
  assign eat       = fire && quasi;
  assign cpl_load  = eat && is_cfg;
  assign cpl_next  = build_cpl(cpl_id, rid, tag, is_cfg0 ? ST_CRS : ST_UR);

  qrst_cpl_stage u_cpl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cpl_load),
    .hdr_in (cpl_next),
    .ready  (cpl_ready),
    .valid  (cpl_valid),
    .hdr    (cpl_hdr),
    .space  (cpl_space)
  );

  qrst_credit_out u_crd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (eat),
    .cls_in   (cls),
    .dcred_in (dcred),
    .valid    (crd_valid),
    .cls      (crd_class),
    .data     (crd_data)
  );

  // R9: a waiting header keeps the mode it was presented under
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (quasi == $past(quasi)));
  // R2: a passed-through header never returns credit here
  a_r2_pass_no_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !crd_valid);
  // R7: every consumed header returns credit next cycle
  a_r7_eat_credit: assert property (@(posedge clk) disable iff (!rst_n)
    eat |=> crd_valid);
  // R3: an accepted configuration request is answered next cycle
  a_r3_cfg_answered: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_load |=> cpl_valid);
  // R5: completion status is retry or unsupported only
  a_r5_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (cpl_hdr[47:45] == ST_CRS || cpl_hdr[47:45] == ST_UR));
endmodule

// File: tb/qrst_cfg_responder_test.sv
`timescale 1ns/1ps
module qrst_cfg_responder_test;
  logic         clk = 0, rst_n = 0, qrst = 0;
  logic [15:0]  cpl_id = 16'hBEEF;
  logic         in_valid = 0, out_ready = 1, cpl_ready = 1;
  logic [127:0] in_hdr = '0;
  logic         in_ready, out_valid, cpl_valid, crd_valid;
  logic [127:0] out_hdr;
  logic [95:0]  cpl_hdr;
  logic [1:0]   crd_class;
  logic [8:0]   crd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qrst_cfg_responder uut (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [2:0] fmt, input logic [4:0] ty,
      input logic [9:0] len, input logic [15:0] rid, input logic [7:0] tag,
      input logic [31:0] dw2);
    return {fmt, ty, 14'd0, len, rid, tag, 8'hFF, dw2, 32'd0};
  endfunction

  function automatic logic [95:0] exp_cpl(input logic [15:0] rid, input logic [7:0] tag,
                                          input logic [2:0] st);
    return {32'h0A00_0000, cpl_id, st, 13'd4, rid, tag, 8'h00};
  endfunction

  // present header, wait for acceptance; returns at the negedge after accepting edge
  task automatic send(input logic [127:0] h);
    @(negedge clk);
    in_hdr = h; in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
    #1;
  endtask

  task automatic t_reset;
    chk(cpl_valid == 0, "R1 cpl_valid", cpl_valid, 0);
    chk(crd_valid == 0, "R1 crd_valid", crd_valid, 0);
  endtask

  task automatic t_pass;
    logic [127:0] h;
    h = mk(3'b011, 5'b00000, 10'd8, 16'h1111, 8'h22, 32'h1234_5678);
    qrst = 0; out_ready = 0;
    @(negedge clk); in_hdr = h; in_valid = 1; #1;
    chk(out_valid == 1, "R2 out_valid", out_valid, 1);
    chk(out_hdr == h, "R2 out_hdr", out_hdr, h);
    chk(in_ready == 0, "R2 ready follows out_ready", in_ready, 0);
    out_ready = 1; #1;
    chk(in_ready == 1, "R2 ready high", in_ready, 1);
    @(negedge clk); in_valid = 0; #1;
    chk(!cpl_valid && !crd_valid, "R2 no cpl/credit", {cpl_valid, crd_valid}, 0);
  endtask

  task automatic t_cfg0;
    qrst = 1;
    send(mk(3'b000, 5'b00100, 10'd1, 16'h0A0B, 8'h31, 32'h0100_0040));
    chk(cpl_valid && cpl_hdr == exp_cpl(16'h0A0B, 8'h31, 3'b010), "R3 R5 cfgrd0 retry",
        cpl_hdr, exp_cpl(16'h0A0B, 8'h31, 3'b010));
    chk(crd_valid && crd_class == 1 && crd_data == 0, "R7 cfgrd0 credit",
        {crd_valid, crd_class, crd_data}, {1'b1, 2'd1, 9'd0});
    // write to the global address-space access / data register pair: still retry
    send(mk(3'b010, 5'b00100, 10'd1, 16'h0C0D, 8'h32, 32'h0000_00FC));
    chk(cpl_valid && cpl_hdr == exp_cpl(16'h0C0D, 8'h32, 3'b010), "R3 cfgwr0 any addr",
        cpl_hdr, exp_cpl(16'h0C0D, 8'h32, 3'b010));
    chk(crd_valid && crd_data == 1, "R8 cfgwr0 one data credit", crd_data, 1);
    @(negedge clk); #1;
    chk(!crd_valid && !cpl_valid, "R7 single pulse", {crd_valid, cpl_valid}, 0);
  endtask

  task automatic t_cfg1;
    qrst = 1;
    send(mk(3'b000, 5'b00101, 10'd1, 16'h7777, 8'h40, 32'h0203_0000));
    chk(cpl_valid && cpl_hdr == exp_cpl(16'h7777, 8'h40, 3'b001), "R4 cfg1 UR",
        cpl_hdr, exp_cpl(16'h7777, 8'h40, 3'b001));
  endtask

  task automatic t_drop(input logic [2:0] fmt, input logic [4:0] ty, input logic [9:0] len,
                        input logic [1:0] ecls, input logic [8:0] edat, input string tag);
    qrst = 1;
    @(negedge clk); in_hdr = mk(fmt, ty, len, 16'h5555, 8'h01, 0); in_valid = 1; #1;
    chk(in_ready && !out_valid, {"R6 drop accept ", tag}, {in_ready, out_valid}, 2'b10);
    @(negedge clk); in_valid = 0; #1;
    chk(!cpl_valid, {"R6 no cpl ", tag}, cpl_valid, 0);
    chk(crd_valid && crd_class == ecls && crd_data == edat, {"R7 R8 credit ", tag},
        {crd_valid, crd_class, crd_data}, {1'b1, ecls, edat});
  endtask

  task automatic t_stall;
    qrst = 1; cpl_ready = 0;
    send(mk(3'b000, 5'b00100, 10'd1, 16'hA001, 8'h10, 0));
    @(negedge clk); in_hdr = mk(3'b000, 5'b00101, 10'd1, 16'hA002, 8'h11, 0); in_valid = 1; #1;
    chk(in_ready == 0, "R10 backpressure", in_ready, 0);
    repeat (3) @(negedge clk); #1;
    chk(cpl_valid && cpl_hdr == exp_cpl(16'hA001, 8'h10, 3'b010), "R10 held",
        cpl_hdr, exp_cpl(16'hA001, 8'h10, 3'b010));
    chk(!crd_valid, "R10 no early credit", crd_valid, 0);
    cpl_ready = 1; #1;
    chk(in_ready == 1, "R10 drain frees slot", in_ready, 1);
    @(negedge clk); in_valid = 0; #1;
    chk(cpl_valid && cpl_hdr == exp_cpl(16'hA002, 8'h11, 3'b001), "R10 handover",
        cpl_hdr, exp_cpl(16'hA002, 8'h11, 3'b001));
    chk(crd_valid, "R7 credit on handover", crd_valid, 1);
    @(negedge clk); #1;
    chk(!cpl_valid && !crd_valid, "R10 answered once", {cpl_valid, crd_valid}, 0);
  endtask

  task automatic t_mode_switch;
    logic [127:0] h;
    h = mk(3'b001, 5'b00000, 10'd4, 16'h9999, 8'h05, 32'h8000_0000);
    qrst = 0; out_ready = 0;
    @(negedge clk); in_hdr = h; in_valid = 1;
    @(negedge clk); qrst = 1; #1;
    chk(out_valid && !in_ready, "R9 stalled header keeps normal mode", {out_valid, in_ready}, 2'b10);
    out_ready = 1;
    @(negedge clk); in_valid = 0; #1;
    chk(!crd_valid && !cpl_valid, "R9 passed, no credit", {crd_valid, cpl_valid}, 0);
    @(negedge clk); in_hdr = h; in_valid = 1; #1;
    chk(!out_valid && in_ready, "R9 next header in quasi mode", {out_valid, in_ready}, 2'b01);
    @(negedge clk); in_valid = 0; #1;
    chk(crd_valid && crd_class == 1, "R9 R7 dropped MRd credit", crd_class, 1);
    qrst = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1; t_reset;
    rst_n = 1;
    t_pass;
    t_cfg0;
    t_cfg1;
    t_drop(3'b011, 5'b00000, 10'd5,  2'd0, 9'd2,   "mwr");
    t_drop(3'b010, 5'b00000, 10'd0,  2'd0, 9'd256, "mwr len0");
    t_drop(3'b000, 5'b00000, 10'd16, 2'd1, 9'd0,   "mrd");
    t_drop(3'b010, 5'b01010, 10'd3,  2'd2, 9'd1,   "cpld");
    t_drop(3'b001, 5'b10000, 10'd0,  2'd0, 9'd0,   "msg");
    t_stall;
    t_mode_switch;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule